// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Handshake Sequencer

This block sequences the two gate enables of one half-bridge. A single PWM command picks which switch should conduct (1 = high side, 0 = low side). Each switch has a digital comparator flag from its gate-to-source voltage monitor (1 = gate seen on). When the command changes, the block turns the outgoing gate off. It waits until that gate's monitor reports it off, counts a programmable digital dead time, and only then enables the incoming gate. Dead time therefore follows the real turn-off of the outgoing switch rather than a fixed guess.

Every commanded transition also starts a programmable drive window. While the window runs, the gate opposite to the commanded side gets a strong-pulldown select, which holds it against coupled charge while the switch node slews. When the window closes, both monitors are checked against the expected levels: the commanded gate on and the opposite gate off. A mismatch, including a handshake that never completed, raises a sticky gate fault. The fault forces both gates off with both pulldowns selected until a synchronous clear. A new command during a window abandons the current one at once, so the window never stretches PWM timing.

The dead-time and window lengths are 8-bit cycle counts taken from input ports at the start of each transition. The PWM and monitor inputs are synchronized with two flops each.

Top module: `hb_gate_seq`

## Requirements
- R1: During and right after reset, both gate enables are 0, both pulldown selects are 1 and the fault flag is 0.
- R2: The incoming gate enable stays 0 for as long as the outgoing side's monitor input reads 1 (gate on).
- R3: With the outgoing monitor already low for the whole wait, the incoming enable rises exactly D+3 clock cycles after the outgoing monitor input falls, where D is the dead-time count sampled at transition start (D = 0 gives 3 cycles).
- R4: After a command change, the pulldown select of the side opposite the new command is 1 for exactly W cycles, where W is the window count sampled at transition start. The commanded side's pulldown stays 0 throughout.
- R5: If the commanded gate's monitor is not 1 when the window closes, the fault flag rises and the enabled gate is switched off.
- R6: If the outgoing monitor never falls during the window (gate stuck on), the incoming gate is never enabled and the fault flag rises when the window closes.
- R7: A command change during a window restarts the sequence for the new command with a fresh window. The abandoned window raises no fault.
- R8: The fault flag is sticky. While it is set, both enables are 0, both pulldowns are 1, and PWM changes have no effect.
- R9: A one-cycle pulse on the clear input while faulted drops the fault flag the next cycle, and a new transition toward the current command begins.
- R10: The high-side and low-side enables are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Commanded side: 1 high side, 0 low side (asynchronous) |
| hs_vgs_i | input | 1 | High-side gate monitor, 1 = on (asynchronous) |
| ls_vgs_i | input | 1 | Low-side gate monitor, 1 = on (asynchronous) |
| dead_cyc_i | input | 8 | Digital dead time in cycles, sampled at transition start |
| win_cyc_i | input | 8 | Drive window length in cycles, sampled at transition start |
| flt_clr_i | input | 1 | Synchronous fault clear pulse |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| hs_pd_o | output | 1 | High-side strong-pulldown select |
| ls_pd_o | output | 1 | Low-side strong-pulldown select |
| gate_flt_o | output | 1 | Sticky gate-fault flag |

## Verification
The bench holds the outgoing monitor high well past the dead time. A sequencer that fell back on a timer would enable the incoming gate early and overlap conduction. It measures the enable latency for a nonzero and a zero dead time, which catches an off-by-one in the dead-time counter. It counts the pulldown cycles exactly, which exposes a window one cycle long or short. It reverses the command inside a window where the first transition would have timed out, so a design that failed to reload the window raises a false fault. Stuck-on and stuck-off monitors must each end in the latched safe state and ignore PWM until the clear.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DEAD,
    ST_ON,
    ST_FAULT
  } hb_st_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hb_dcnt.sv
module hb_dcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= val_i;
    else if (dec_i && (cnt_q != '0))     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             hs_vgs_i,
  input  logic             ls_vgs_i,
  input  logic [CNT_W-1:0] dead_cyc_i,
  input  logic [CNT_W-1:0] win_cyc_i,
  input  logic             flt_clr_i,
  output logic             hs_en_o,
  output logic             ls_en_o,
  output logic             hs_pd_o,
  output logic             ls_pd_o,
  output logic             gate_flt_o
);
  import hb_gate_pkg::*;

  localparam int NSYNC = 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NSYNC-1:0] raw_in, syn_in;
  logic pwm_s, hs_s, ls_s;

  assign raw_in = {pwm_i, hs_vgs_i, ls_vgs_i};

  hb_sync #(.W(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {pwm_s, hs_s, ls_s} = syn_in;

  hb_st_e st_q;
  logic   cmd_q;
  logic   flt_q;
  logic   start, win_exp, chk_bad;
  logic   tgt_on, out_on;
  logic [CNT_W-1:0] dead_cnt, win_cnt;

  // target = side being commanded on, out = the other one
  assign tgt_on = cmd_q ? hs_s : ls_s;
  assign out_on = cmd_q ? ls_s : hs_s;

  assign start   = (st_q == ST_IDLE) ||
                   ((st_q != ST_FAULT) && (pwm_s != cmd_q));
  assign win_exp = (win_cnt == ONE) && !start && (st_q != ST_FAULT);
  assign chk_bad = (st_q != ST_ON) || !tgt_on || out_on;

  hb_dcnt #(.W(CNT_W)) u_dead (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .val_i (dead_cyc_i),
    .dec_i (st_q == ST_DEAD),
    .cnt_o (dead_cnt)
  );

  hb_dcnt #(.W(CNT_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .val_i (win_cyc_i),
    .dec_i (1'b1),
    .cnt_o (win_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cmd_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (st_q == ST_FAULT) begin
      if (flt_clr_i) begin
        st_q  <= ST_IDLE;
        flt_q <= 1'b0;
      end
    end else if (start) begin
      cmd_q <= pwm_s;
      st_q  <= ST_WAIT;
    end else if (win_exp && chk_bad) begin
      st_q  <= ST_FAULT;
      flt_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_WAIT: if (!out_on) st_q <= (dead_cnt == '0) ? ST_ON : ST_DEAD;
        ST_DEAD: if (dead_cnt == ONE) st_q <= ST_ON;
        default: ;
      endcase
    end
  end

  logic safe;
  logic win_act;
  assign safe    = (st_q == ST_IDLE) || (st_q == ST_FAULT);
  assign win_act = (win_cnt != '0) && !safe;

  assign hs_en_o    = (st_q == ST_ON) &&  cmd_q;
  assign ls_en_o    = (st_q == ST_ON) && !cmd_q;
  assign hs_pd_o    = safe || (win_act && !cmd_q);
  assign ls_pd_o    = safe || (win_act &&  cmd_q);
  assign gate_flt_o = flt_q;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flt_clr_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic hs_pd_o,
  input logic ls_pd_o,
  input logic gate_flt_o
);
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  p_flt_safe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_flt_o |-> (!hs_en_o && !ls_en_o && hs_pd_o && ls_pd_o));

  p_flt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_flt_o && !flt_clr_i) |=> gate_flt_o);

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_flt_o && flt_clr_i) |=> !gate_flt_o);

  p_hs_no_pd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> !hs_pd_o);

  p_ls_no_pd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_en_o |-> !ls_pd_o);
endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flt_clr_i (flt_clr_i),
  .hs_en_o   (hs_en_o),
  .ls_en_o   (ls_en_o),
  .hs_pd_o   (hs_pd_o),
  .ls_pd_o   (ls_pd_o),
  .gate_flt_o(gate_flt_o)
);

// File: tb/hb_gate_seq_bench.sv
module hb_gate_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, hs_vgs = 1'b0, ls_vgs = 1'b0, clr = 1'b0;
  logic [7:0] dead = 8'd2, win = 8'd20;
  logic hs_en, ls_en, hs_pd, ls_pd, flt;
  int n_run = 0, n_fail = 0, n_overlap = 0;

  always #2 clk = ~clk;

  hb_gate_seq u_hb_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .hs_vgs_i(hs_vgs),
    .ls_vgs_i(ls_vgs), .dead_cyc_i(dead), .win_cyc_i(win),
    .flt_clr_i(clr), .hs_en_o(hs_en), .ls_en_o(ls_en),
    .hs_pd_o(hs_pd), .ls_pd_o(ls_pd), .gate_flt_o(flt)
  );

  always @(negedge clk) if (hs_en && ls_en) n_overlap++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en(input bit hs, output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (hs ? hs_en : ls_en) break;
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk(!hs_en && !ls_en, "R1 enables", {hs_en, ls_en}, 0);
    chk(hs_pd && ls_pd, "R1 pulldowns", {hs_pd, ls_pd}, 3);
    chk(!flt, "R1 fault", flt, 0);
    rst_n = 1'b1;
    begin
      int n;
      wait_en(1'b0, n);
      ls_vgs = 1'b1;
    end
    cyc(30);
    chk(ls_en && !flt, "R1 first transition", {ls_en, flt}, 2);
  endtask

  task automatic t_dead();
    int n; bit early;
    dead = 8'd5; win = 8'd40;
    pwm = 1'b1;
    early = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hs_en) early = 1;
    end
    chk(!early, "R2 no enable while outgoing on", early, 0);
    ls_vgs = 1'b0;
    wait_en(1'b1, n);
    chk(n == 8, "R3 dead time D=5", n, 8);
    hs_vgs = 1'b1;
    cyc(50);
    chk(!flt, "R3 no fault", flt, 0);
    dead = 8'd0;
    pwm = 1'b0;
    cyc(6);
    hs_vgs = 1'b0;
    wait_en(1'b0, n);
    chk(n == 3, "R3 dead time D=0", n, 3);
    ls_vgs = 1'b1;
    cyc(50);
    chk(!flt && ls_en, "R3 settled low side", {flt, ls_en}, 1);
  endtask

  task automatic t_pulldown();
    int cnt_hs; int cnt_ls;
    dead = 8'd2; win = 8'd12;
    pwm = 1'b1; ls_vgs = 1'b0;
    cyc(4);
    while (!hs_en) @(negedge clk);
    hs_vgs = 1'b1;
    cyc(30);
    cnt_hs = 0; cnt_ls = 0;
    pwm = 1'b0; hs_vgs = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hs_pd) cnt_hs++;
      if (ls_pd) cnt_ls++;
      if (ls_en && !ls_vgs) ls_vgs = 1'b1;
    end
    chk(cnt_hs == 12, "R4 opposite pulldown length", cnt_hs, 12);
    chk(cnt_ls == 0, "R4 incoming pulldown", cnt_ls, 0);
    chk(!flt && ls_en, "R4 transition ok", {flt, ls_en}, 1);
  endtask

  task automatic t_restart();
    bit seen_hs;
    dead = 8'd2; win = 8'd20;
    pwm = 1'b1;
    cyc(4);
    pwm = 1'b0;
    seen_hs = 0;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      if (hs_en) seen_hs = 1;
    end
    chk(!seen_hs, "R7 aborted side not enabled", seen_hs, 0);
    chk(!flt, "R7 no fault from aborted window", flt, 0);
    chk(ls_en, "R7 new command served", ls_en, 1);
  endtask

  task automatic t_stuck_on();
    bit seen_hs;
    win = 8'd20;
    pwm = 1'b1;
    seen_hs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hs_en) seen_hs = 1;
    end
    chk(!seen_hs, "R6 incoming never enabled", seen_hs, 0);
    chk(flt, "R6 handshake timeout fault", flt, 1);
  endtask

  task automatic t_clear();
    int n;
    ls_vgs = 1'b0; hs_vgs = 1'b0;
    cyc(4);
    chk(flt, "R8 still faulted before clear", flt, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!flt, "R9 clear drops fault", flt, 0);
    wait_en(1'b1, n);
    chk(n <= 6, "R9 new transition after clear", n, 6);
    hs_vgs = 1'b1;
    cyc(40);
    chk(!flt && hs_en, "R9 settled high side", {flt, hs_en}, 1);
  endtask

  task automatic t_stuck_off();
    bit bad;
    win = 8'd16;
    pwm = 1'b0; hs_vgs = 1'b0;
    cyc(30);
    chk(flt, "R5 commanded gate never on", flt, 1);
    chk(!ls_en && !hs_en, "R5 gate switched off", {hs_en, ls_en}, 0);
    pwm = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!flt || hs_en || ls_en || !hs_pd || !ls_pd) bad = 1;
    end
    chk(!bad, "R8 pwm ignored while faulted", bad, 0);
  endtask

  initial begin
    t_reset();
    t_dead();
    t_pulldown();
    t_restart();
    t_stuck_on();
    t_clear();
    t_stuck_off();
    chk(n_overlap == 0, "R10 enables overlap", n_overlap, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule